// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register bank of an I/O address translation unit. A host reaches it through a simple register bus with valid/ready signals, using whole 32-bit words only. Every register has its own write mask and its own bits that are forced to one. Some registers also have side effects. The control register selects the size of the device virtual address window, and the block continuously drives the window's base address to the translation engine. One identification register only gains bits: each write ORs its data into the current contents.

The block also holds the fault status and fault address pair and drives a level interrupt from them. When the translation engine finds a bad access, it pulses a capture strobe with the faulting address and the direction of the access. The block then loads both fault registers and raises the interrupt. Any bus read or write of either fault register drops the interrupt again. The two flush registers only store the value written to them and start no action. Offsets that are not mapped read as zero and ignore writes.

Top module: `ioxlat_regbank`

## Requirements
- R1: A synchronous active-low reset loads the registers as follows.
  - Control (byte offset 0x0000) = version word {IMPL_ID, VER_ID, 24'h0}, which is 0x41000000 by default.
  - Bus-arbiter (0x2000) = 0x00000008.
  - Fault status (0x1000) = 0x00800000.
  - Arbiter-enable (0x1008) = 0x00000003.
  - Identification mask (0x3018) = 0x23000000.
  - Table base (0x0004), full flush (0x0014), page flush (0x0018), fault address (0x1004) and the four slot registers (0x1010, 0x1014, 0x1018, 0x101C) = 0.
  - Window base output = 0 and interrupt = 0.
- R2: A control write stores (data AND 0x0000001D) OR the version word.
- R3: A control write sets the window base output, due the cycle after the write, from data bits 4:2. Code n selects a window of 16MB shifted left by n, so the base is 0xFFFFFFFF shifted left by (24+n). Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: A table-base write stores data AND 0x07FFFC00. Both flush registers store the full 32-bit word.
- R5: A fault status write stores (data AND 0xFF0FFFFF) OR 0x00800000. A fault address write stores the full word.
- R6: The remaining masked registers store as follows.
  - Arbiter-enable stores (data AND 0x801F000F) OR 0x00000001.
  - Each slot register stores data AND 0x00010003.
  - Bus-arbiter stores (data AND 0x001F0000) OR 0x00000008.
- R7: An identification mask write stores old OR (data AND 0x00FFFFFF). No bit is ever cleared.
- R8: req_ready is always 1. A read accepted on one edge gives rd_valid high for one cycle with the register value on rd_data after that edge. An unmapped offset reads 0, and a write to it changes no register. Address bits 1:0 are ignored.
- R9: A capture strobe loads fault address = flt_addr. It loads fault status = 0xC0820000 for a write fault and 0xC0860000 for a read fault (bit 18 set). The interrupt is high from the next cycle.
- R10: A bus read or write of the fault status or fault address register, without a capture in the same cycle, clears the interrupt on the next cycle.
- R11: When a capture strobe and a bus write to a fault register arrive in the same cycle, the capture values are stored and the interrupt stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (14) | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |
| rd_data | output | 32 | Read data |
| flt_capture | input | 1 | Fault capture strobe from the translation engine |
| flt_is_write | input | 1 | The faulting access was a write |
| flt_addr | input | 32 | Faulting address |
| win_base | output | 32 | Base address of the translation window |
| irq | output | 1 | Level fault interrupt |

## Verification
Every result of this block is registered exactly once. Read data, the window base and the interrupt therefore all become valid on the edge that accepts the request or the capture strobe. The bench drives each operation at a falling edge and lets one rising edge accept it. It then samples all outputs at the following falling edge, the first point at which the new values are stable. The interrupt is compared after every operation against a model. In that model a capture sets the interrupt and any access to a fault register clears it. Register contents are compared on readback against masked values that bench functions compute.

// File: rtl/ioxlat_pkg.sv
// Package: shared offsets, masks and register selector type for the
// I/O translation register bank. Offsets are byte offsets on the bus.
package ioxlat_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_BASE,
        SEL_FLUSH_ALL,
        SEL_FLUSH_PAGE,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_ARBEN,
        SEL_SLOT,
        SEL_BUSARB,
        SEL_IDMASK
    } reg_sel_e;

    localparam int OFF_CTRL       = 'h0000;
    localparam int OFF_BASE       = 'h0004;
    localparam int OFF_FLUSH_ALL  = 'h0014;
    localparam int OFF_FLUSH_PAGE = 'h0018;
    localparam int OFF_FSTAT      = 'h1000;
    localparam int OFF_FADDR      = 'h1004;
    localparam int OFF_ARBEN      = 'h1008;
    localparam int OFF_SLOT0      = 'h1010;
    localparam int OFF_BUSARB     = 'h2000;
    localparam int OFF_IDMASK     = 'h3018;

    localparam logic [31:0] CTRL_KEEP    = 32'h0000_001D;
    localparam logic [31:0] BASE_KEEP    = 32'h07FF_FC00;
    localparam logic [31:0] FSTAT_KEEP   = 32'hFF0F_FFFF;
    localparam logic [31:0] FSTAT_FORCE  = 32'h0080_0000;
    localparam logic [31:0] ARBEN_KEEP   = 32'h801F_000F;
    localparam logic [31:0] ARBEN_FORCE  = 32'h0000_0001;
    localparam logic [31:0] SLOT_KEEP    = 32'h0001_0003;
    localparam logic [31:0] BUSARB_KEEP  = 32'h001F_0000;
    localparam logic [31:0] BUSARB_FORCE = 32'h0000_0008;
    localparam logic [31:0] IDMASK_KEEP  = 32'h00FF_FFFF;

    localparam logic [31:0] ARBEN_RESET  = 32'h0000_0003;
    localparam logic [31:0] IDMASK_RESET = 32'h2300_0000;

    // Fault capture: error, late-error, reserved-one and address-valid flags.
    localparam logic [31:0] FLT_CAP_BASE = 32'hC082_0000;
    localparam logic [31:0] FLT_RD_FLAG  = 32'h0004_0000;

endpackage

// File: rtl/ioxlat_addr_decode.sv
// Module: ioxlat_addr_decode
// Turns a bus byte offset into a register selector and a slot index.
// Assumes word accesses only: address bits 1:0 are not decoded.
module ioxlat_addr_decode
    import ioxlat_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [SLOT_W-1:0] slot_idx
);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int SLOT_W0 = OFF_SLOT0 >> 2;

    logic [WORD_W-1:0] word;
    logic [1:0]        unused_lo;
    int                word_i;

    assign word      = addr[ADDR_W-1:2];
    assign unused_lo = addr[1:0];
    assign word_i    = int'({{(32-WORD_W){1'b0}}, word});

    // Match the word offset against each mapped register.
    always_comb begin
        sel      = SEL_NONE;
        slot_idx = '0;
        if (word_i == (OFF_CTRL >> 2))            sel = SEL_CTRL;
        else if (word_i == (OFF_BASE >> 2))       sel = SEL_BASE;
        else if (word_i == (OFF_FLUSH_ALL >> 2))  sel = SEL_FLUSH_ALL;
        else if (word_i == (OFF_FLUSH_PAGE >> 2)) sel = SEL_FLUSH_PAGE;
        else if (word_i == (OFF_FSTAT >> 2))      sel = SEL_FSTAT;
        else if (word_i == (OFF_FADDR >> 2))      sel = SEL_FADDR;
        else if (word_i == (OFF_ARBEN >> 2))      sel = SEL_ARBEN;
        else if (word_i == (OFF_BUSARB >> 2))     sel = SEL_BUSARB;
        else if (word_i == (OFF_IDMASK >> 2))     sel = SEL_IDMASK;
        else if (word_i >= SLOT_W0 && word_i < SLOT_W0 + NUM_SLOTS) begin
            sel      = SEL_SLOT;
            slot_idx = SLOT_W'(word_i - SLOT_W0);
        end
    end
endmodule

// File: rtl/ioxlat_window_decode.sv
// Module: ioxlat_window_decode
// Maps a 3-bit size code to the base of a window that ends at the top of
// the address space. Code 0 is the smallest window, 2**MIN_LOG2 bytes.
// Assumes MIN_LOG2 + 7 < VA_W.
module ioxlat_window_decode #(
    parameter int VA_W     = 32,
    parameter int MIN_LOG2 = 24
) (
    input  logic [2:0]      size_code,
    output logic [VA_W-1:0] base
);
    // All ones above the window size, zeros below it.
    always_comb begin
        base = {VA_W{1'b1}} << (MIN_LOG2 + int'(size_code));
    end
endmodule

// File: rtl/ioxlat_fault_regs.sv
// Module: ioxlat_fault_regs
// Holds the fault status and fault address registers and the level
// interrupt. A capture from the translation engine wins over a bus write
// in the same cycle. Any bus access to either register drops the interrupt.
module ioxlat_fault_regs
    import ioxlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_stat,
    input  logic        wr_addr,
    input  logic        access,
    input  logic [31:0] wdata,
    input  logic        cap,
    input  logic        cap_is_write,
    input  logic [31:0] cap_addr,
    output logic [31:0] fstat,
    output logic [31:0] faddr,
    output logic        irq
);
    logic [31:0] cap_stat;

    // Status word that a capture loads, with the read flag for read faults.
    always_comb begin
        cap_stat = FLT_CAP_BASE | (cap_is_write ? 32'h0 : FLT_RD_FLAG);
    end

    // Fault status: capture first, then a masked bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       fstat <= FSTAT_FORCE;
        else if (cap)     fstat <= cap_stat;
        else if (wr_stat) fstat <= (wdata & FSTAT_KEEP) | FSTAT_FORCE;
    end

    // Fault address: capture first, then a full-word bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       faddr <= '0;
        else if (cap)     faddr <= cap_addr;
        else if (wr_addr) faddr <= wdata;
    end

    // Level interrupt: set by capture, cleared by any fault-register access.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq <= 1'b0;
        else if (cap)    irq <= 1'b1;
        else if (access) irq <= 1'b0;
    end

    AST_CAP_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> irq); // R9
    AST_ACCESS_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !cap) |=> !irq); // R10
    AST_CAP_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && wr_addr) |=> (faddr == $past(cap_addr))); // R11
    AST_RESV_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fstat[23]); // R5
endmodule

// File: rtl/ioxlat_regbank.sv
// Module: ioxlat_regbank (top)
// Register bank of an I/O address translation unit on a word-wide register
// bus. Each register has its own write mask and forced bits. The control
// register selects the window size. Read data is registered: it is valid
// one cycle after the request. Assumes one request per cycle and 32-bit
// accesses only.
module ioxlat_regbank
    import ioxlat_pkg::*;
#(
    parameter int         ADDR_W    = 14,
    parameter int         NUM_SLOTS = 4,
    parameter logic [3:0] IMPL_ID   = 4'h4,
    parameter logic [3:0] VER_ID    = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              flt_capture,
    input  logic              flt_is_write,
    input  logic [31:0]       flt_addr,
    output logic [31:0]       win_base,
    output logic              irq
);
    localparam int          SLOT_W       = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [31:0] VERSION_WORD = {IMPL_ID, VER_ID, 24'h0};

    reg_sel_e          sel;
    logic [SLOT_W-1:0] slot_idx;
    logic              wr_fire;
    logic              rd_fire;
    logic [31:0]       ctrl_q, base_q, flush_all_q, flush_page_q;
    logic [31:0]       arben_q, busarb_q, idmask_q;
    logic [31:0]       slot_q [NUM_SLOTS];
    logic [31:0]       fstat_q, faddr_q;
    logic [31:0]       win_next;
    logic [31:0]       rd_mux;
    logic              fault_access;

    assign req_ready    = 1'b1;
    assign wr_fire      = req_valid && req_write;
    assign rd_fire      = req_valid && !req_write;
    assign fault_access = req_valid && (sel == SEL_FSTAT || sel == SEL_FADDR);

    ioxlat_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_decode (
        .addr(req_addr), .sel(sel), .slot_idx(slot_idx)
    );

    ioxlat_window_decode #(
        .VA_W(32), .MIN_LOG2(24)
    ) u_window (
        .size_code(req_wdata[4:2]), .base(win_next)
    );

    ioxlat_fault_regs u_fault (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(wr_fire && sel == SEL_FSTAT),
        .wr_addr(wr_fire && sel == SEL_FADDR),
        .access(fault_access),
        .wdata(req_wdata),
        .cap(flt_capture), .cap_is_write(flt_is_write), .cap_addr(flt_addr),
        .fstat(fstat_q), .faddr(faddr_q), .irq(irq)
    );

    // Control: masked value with the fixed version byte ORed in.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ctrl_q <= VERSION_WORD;
        else if (wr_fire && sel == SEL_CTRL)  ctrl_q <= (req_wdata & CTRL_KEEP) | VERSION_WORD;
    end

    // Window base: decoded from the size code on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                           win_base <= '0;
        else if (wr_fire && sel == SEL_CTRL)  win_base <= win_next;
    end

    // Page-table base: only the aligned address bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)                           base_q <= '0;
        else if (wr_fire && sel == SEL_BASE)  base_q <= req_wdata & BASE_KEEP;
    end

    // Flush registers: store the written word, no action follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all_q  <= '0;
            flush_page_q <= '0;
        end else if (wr_fire) begin
            if (sel == SEL_FLUSH_ALL)  flush_all_q  <= req_wdata;
            if (sel == SEL_FLUSH_PAGE) flush_page_q <= req_wdata;
        end
    end

    // Arbiter enable: masked, with bit 0 always set.
    always_ff @(posedge clk) begin
        if (!rst_n)                           arben_q <= ARBEN_RESET;
        else if (wr_fire && sel == SEL_ARBEN) arben_q <= (req_wdata & ARBEN_KEEP) | ARBEN_FORCE;
    end

    // Per-slot configuration registers, one per slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Slot g: masked store when its offset is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_fire && sel == SEL_SLOT && slot_idx == SLOT_W'(g))
                slot_q[g] <= req_wdata & SLOT_KEEP;
        end
    end

    // Bus arbiter: masked, with bit 3 always set.
    always_ff @(posedge clk) begin
        if (!rst_n)                            busarb_q <= BUSARB_FORCE;
        else if (wr_fire && sel == SEL_BUSARB) busarb_q <= (req_wdata & BUSARB_KEEP) | BUSARB_FORCE;
    end

    // Identification mask: accumulates written bits, never clears them.
    always_ff @(posedge clk) begin
        if (!rst_n)                            idmask_q <= IDMASK_RESET;
        else if (wr_fire && sel == SEL_IDMASK) idmask_q <= idmask_q | (req_wdata & IDMASK_KEEP);
    end

    // Read mux: current register value, zero for unmapped offsets.
    always_comb begin
        case (sel)
            SEL_CTRL:       rd_mux = ctrl_q;
            SEL_BASE:       rd_mux = base_q;
            SEL_FLUSH_ALL:  rd_mux = flush_all_q;
            SEL_FLUSH_PAGE: rd_mux = flush_page_q;
            SEL_FSTAT:      rd_mux = fstat_q;
            SEL_FADDR:      rd_mux = faddr_q;
            SEL_ARBEN:      rd_mux = arben_q;
            SEL_SLOT:       rd_mux = slot_q[slot_idx];
            SEL_BUSARB:     rd_mux = busarb_q;
            SEL_IDMASK:     rd_mux = idmask_q;
            default:        rd_mux = '0;
        endcase
    end

    // Read response register: one-cycle valid pulse with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_fire;
            rd_data  <= rd_fire ? rd_mux : '0;
        end
    end

    AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write)); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(sel == SEL_NONE)) |-> (rd_data == 32'h0)); // R8
    AST_WIN_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base[23:0] == 24'h0)); // R3
    AST_IDMASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(idmask_q) & ~idmask_q) == 32'h0)); // R7
    AST_CTRL_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[31:24] == VERSION_WORD[31:24])); // R2
endmodule

// File: tb/sim_ioxlat_regbank.sv
// Bench for ioxlat_regbank: directed corner cases, then seeded random
// operations checked against a model built from bench functions.
module sim_ioxlat_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [13:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        flt_capture = 1'b0, flt_is_write = 1'b0;
    logic [31:0] flt_addr = '0;
    logic [31:0] win_base;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [13:0] OFFS [13] = '{14'h0000, 14'h0004, 14'h0014, 14'h0018,
        14'h1000, 14'h1004, 14'h1008, 14'h1010, 14'h1014, 14'h1018, 14'h101C,
        14'h2000, 14'h3018};
    localparam logic [31:0] VERW = 32'h4100_0000;

    logic [31:0] m [13];
    logic        irq_m;
    logic [31:0] win_m;

    always #2 clk = ~clk;

    ioxlat_regbank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .flt_capture(flt_capture),
        .flt_is_write(flt_is_write), .flt_addr(flt_addr), .win_base(win_base),
        .irq(irq)
    );

    function automatic logic [31:0] reset_val(int i);
        case (i)
            0:  return VERW;
            4:  return 32'h0080_0000;
            6:  return 32'h0000_0003;
            11: return 32'h0000_0008;
            12: return 32'h2300_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] next_val(int i, logic [31:0] old, logic [31:0] d);
        case (i)
            0:  return (d & 32'h0000_001D) | VERW;
            1:  return d & 32'h07FF_FC00;
            2, 3, 5: return d;
            4:  return (d & 32'hFF0F_FFFF) | 32'h0080_0000;
            6:  return (d & 32'h801F_000F) | 32'h0000_0001;
            7, 8, 9, 10: return d & 32'h0001_0003;
            11: return (d & 32'h001F_0000) | 32'h0000_0008;
            default: return old | (d & 32'h00FF_FFFF);
        endcase
    endfunction

    function automatic logic [31:0] win_of(logic [31:0] d);
        return 32'hFFFF_FFFF << (24 + int'(d[4:2]));
    endfunction

    function automatic bit is_mapped(logic [13:0] a);
        for (int k = 0; k < 13; k++) if (OFFS[k][13:2] == a[13:2]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // One operation: drive at falling edge, one accepting edge, sample at next fall.
    task automatic op(bit v, bit w, logic [13:0] a, logic [31:0] d,
                      bit cap, bit capw, logic [31:0] capa);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        flt_capture = cap; flt_is_write = capw; flt_addr = capa;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; req_write = 0; flt_capture = 0;
    endtask

    task automatic rd_chk(string req, int i);
        op(1, 0, OFFS[i], 32'h0, 0, 0, 0);
        chk({req, " rd_valid"}, 32'(rd_valid), 32'h1);
        chk(req, rd_data, m[i]);
        if (i == 4 || i == 5) irq_m = 0;
    endtask

    task automatic wr_do(int i, logic [31:0] d);
        op(1, 1, OFFS[i], d, 0, 0, 0);
        m[i] = next_val(i, m[i], d);
        if (i == 0) win_m = win_of(d);
        if (i == 4 || i == 5) irq_m = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 13; i++) m[i] = reset_val(i);
        irq_m = 0; win_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state of outputs and every register.
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 win_base", win_base, 32'h0);
        chk("R8 req_ready", 32'(req_ready), 32'h1);
        for (int i = 0; i < 13; i++) rd_chk("R1 reset value", i);

        // R2/R3: control write with all ones, then every size code.
        wr_do(0, 32'hFFFF_FFFF);
        chk("R3 win 2GB", win_base, 32'h8000_0000);
        rd_chk("R2 ctrl mask/version", 0);
        chk("R2 ctrl exact", m[0], 32'h4100_001D);
        for (int c = 0; c < 8; c++) begin
            wr_do(0, 32'(c) << 2);
            chk("R3 window code", win_base, win_m);
        end
        chk("R3 code7 base", win_m, 32'h8000_0000);

        // R4/R5/R6: masks and forced bits with all-ones and zero data.
        for (int i = 1; i < 12; i++) begin
            wr_do(i, 32'hFFFF_FFFF); rd_chk("R4 R5 R6 ones", i);
            wr_do(i, 32'h0);         rd_chk("R4 R5 R6 zeros", i);
        end

        // R7: identification mask only accumulates.
        wr_do(12, 32'h0000_00F0);
        wr_do(12, 32'h0000_000F);
        rd_chk("R7 accumulate", 12);
        chk("R7 exact", m[12], 32'h2300_00FF);
        wr_do(12, 32'hFF00_0000);
        rd_chk("R7 upper byte masked", 12);

        // R8: unmapped write ignored, unmapped read is zero, low bits ignored.
        op(1, 1, 14'h0008, 32'hDEAD_BEEF, 0, 0, 0);
        op(1, 0, 14'h0008, 32'h0, 0, 0, 0);
        chk("R8 unmapped read", rd_data, 32'h0);
        chk("R8 unmapped rd_valid", 32'(rd_valid), 32'h1);
        op(0, 0, 14'h0, 32'h0, 0, 0, 0);
        chk("R8 rd_valid pulse", 32'(rd_valid), 32'h0);
        op(1, 0, OFFS[6] | 14'h3, 32'h0, 0, 0, 0);
        chk("R8 low bits ignored", rd_data, m[6]);

        // R9/R10: read-type capture, then clear by fault address read.
        op(0, 0, 14'h0, 32'h0, 1, 0, 32'h1234_5000);
        m[4] = 32'hC086_0000; m[5] = 32'h1234_5000; irq_m = 1;
        chk("R9 irq raised", 32'(irq), 32'h1);
        rd_chk("R9 read-fault status", 4);
        chk("R10 irq cleared by status read", 32'(irq), 32'h0);
        op(0, 0, 14'h0, 32'h0, 1, 1, 32'hABCD_E000);
        m[4] = 32'hC082_0000; m[5] = 32'hABCD_E000; irq_m = 1;
        rd_chk("R9 fault address", 5);
        chk("R10 irq cleared by address read", 32'(irq), 32'h0);
        op(0, 0, 14'h0, 32'h0, 1, 1, 32'h0000_1000);
        m[5] = 32'h0000_1000;
        wr_do(5, 32'h5555_AAAA);
        chk("R10 irq cleared by address write", 32'(irq), 32'h0);

        // R11: capture and fault-register write in the same cycle.
        op(1, 1, OFFS[4], 32'h0000_0000, 1, 1, 32'h7777_0000);
        m[4] = 32'hC082_0000; m[5] = 32'h7777_0000; irq_m = 1;
        chk("R11 irq kept", 32'(irq), 32'h1);
        op(1, 1, OFFS[5], 32'h1111_1111, 1, 0, 32'h8888_0000);
        m[4] = 32'hC086_0000; m[5] = 32'h8888_0000;
        chk("R11 irq kept on address write", 32'(irq), 32'h1);
        rd_chk("R11 status from capture", 4);
        rd_chk("R11 address from capture", 5);

        // Seeded random mix checked against the model.
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 10);
            if (r < 4) begin
                wr_do(int'($urandom % 13), $urandom);
            end else if (r < 7) begin
                rd_chk("R4 R5 R6 R7 random readback", int'($urandom % 13));
            end else if (r < 9) begin
                logic [13:0] a;
                a = 14'($urandom);
                while (is_mapped(a)) a = 14'($urandom);
                op(1, r == 7, a, $urandom, 0, 0, 0);
                if (r == 8) chk("R8 random unmapped read", rd_data, 32'h0);
            end else begin
                logic [31:0] ca;
                bit cw;
                ca = $urandom; cw = 1'($urandom);
                op(0, 0, 14'h0, 32'h0, 1, cw, ca);
                m[4] = cw ? 32'hC082_0000 : 32'hC086_0000; m[5] = ca; irq_m = 1;
            end
            chk("R9 R10 random irq", 32'(irq), 32'(irq_m));
            chk("R3 random window", win_base, win_m);
        end
        for (int i = 0; i < 13; i++) rd_chk("R8 final readback", i);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule